// File: doc/BRIEF.md
# Optical Sensor Serial Port Master

This block runs register accesses to an optical motion and image sensor over a two-wire synchronous link. The master always drives the serial clock, and one data line carries traffic both ways. A host asks for one register write or one register read through a small request port: an address, a data byte, a direction bit and a start strobe. The block shifts the frame out and, on a read, turns the data line around and captures the returned byte. It then inserts the settle times the sensor needs before a read byte and between commands. It raises `done` for one cycle per command and holds `busy` until the next command may start.

The sensor's serial logic can fall out of step with the master. To recover, the block drives a power-down output for a fixed number of cycles and then waits a recovery interval. It runs this sequence once after reset and again whenever the host asks for it. The data line is split into output, output-enable and input pins, so a pad cell at the chip edge can join them onto one wire.

Top module: `optsens_serial_master`

## Requirements
- R1: After reset is released, `pwrDown` is high for exactly T_PD_WIDTH cycles. `busy` then falls exactly T_PD_RECOV cycles after `pwrDown` falls. Throughout reset and power-down, `sclk` is 1 and `sdioOe` is 0.
- R2: While `busy` is low, `sclk` is high and `sdioOe` is 0.
- R3: A frame is 16 clock pulses. The first byte is the address byte, sent MSB first: bit 7 is 1 for a write and 0 for a read, and bits 6..0 are `reqAddr`. The second byte is the data byte, MSB first. The master changes `sdioOut` only while `sclk` is low, and each bit is taken on the rising edge of `sclk`.
- R4: The data byte of a write equals `reqWdata` as it was in the cycle `reqStart` was accepted, whatever the inputs do later.
- R5: On a read, `sdioOe` is 0 before the sensor drives the line. At least T_ADDR_DATA clock cycles separate the last rising `sclk` edge of the address byte from the first falling edge of the data byte.
- R6: After a read, `rdData` holds the byte the sensor returned, MSB first, when `done` is high. It keeps that value until another read completes.
- R7: `busy` is high in the cycle after a start is accepted in idle. `done` is high for exactly one cycle per command, and only while `busy` is high.
- R8: `busy` falls exactly T_WR_NEXT cycles after the `done` cycle of a write, and exactly T_RD_NEXT cycles after the `done` cycle of a read.
- R9: `reqStart` and `resyncReq` have no effect while `busy` is high: no extra frame and no power-down pulse follow.
- R10: `resyncReq` in idle produces a `pwrDown` pulse of exactly T_PD_WIDTH cycles, followed by T_PD_RECOV cycles of `busy`. It wins over a `reqStart` in the same cycle, and the sensor is back in step afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStart | input | 1 | Start request, sampled in idle |
| reqWrite | input | 1 | 1 = register write, 0 = register read |
| reqAddr | input | 7 | Sensor register address |
| reqWdata | input | 8 | Byte to write |
| resyncReq | input | 1 | Request a power-down resync sequence |
| busy | output | 1 | Command or resync in progress |
| done | output | 1 | One-cycle pulse when a command's frame is finished |
| rdData | output | 8 | Last byte read from the sensor |
| sclk | output | 1 | Serial clock, idles high |
| sdioOut | output | 1 | Serial data driven by the master |
| sdioOe | output | 1 | 1 while the master owns the data line |
| sdioIn | input | 1 | Serial data seen on the line |
| pwrDown | output | 1 | Sensor power-down, active high |

## Verification
A wrong turnaround state shows up within one bit time as both ends driving the data line, or as a read byte shifted by one position in `rdData` at the next `done`. A bit or phase counter that is off by one moves the sensor model's byte boundaries. The written register then receives the wrong value, and the fault shows at the read-back one command later. A wait timer loaded with the wrong interval shows up in the `done` cycle, because `busy` falls on a cycle other than the expected one. A resync path that fails to pulse `pwrDown` leaves a deliberately skewed sensor model out of step, so the first command after the resync returns a wrong value.

// File: rtl/osm_pkg.sv
package osm_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Which value the serializer loads at the start of a byte
  typedef enum logic [1:0] {
    SRC_ADDR,
    SRC_WDATA,
    SRC_RX
  } byteSrc_e;

  // Which interval the shared wait timer loads
  typedef enum logic [2:0] {
    TM_PD,
    TM_REC,
    TM_TURN,
    TM_WR,
    TM_RD
  } timerSel_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic      latchReq;
    logic      byteGo;
    byteSrc_e  src;
    logic      timerGo;
    timerSel_e tsel;
    logic      capture;
  } dpCtl_t;
endpackage

// File: rtl/osm_datapath.sv
module osm_datapath
  import osm_pkg::*;
#(
  parameter int CLK_HALF    = 2,
  parameter int DATA_W      = 8,
  parameter int T_ADDR_DATA = 12,
  parameter int T_WR_NEXT   = 10,
  parameter int T_RD_NEXT   = 6,
  parameter int T_PD_WIDTH  = 8,
  parameter int T_PD_RECOV  = 20,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              sdioIn,
  output logic              byteDone,
  output logic              timerDone,
  output logic              sclk,
  output logic              sdioOut,
  output logic [DATA_W-1:0] rdData
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam int BW = $clog2(DATA_W);
  localparam int M1 = (T_ADDR_DATA > T_WR_NEXT) ? T_ADDR_DATA : T_WR_NEXT;
  localparam int M2 = (T_RD_NEXT > T_PD_WIDTH) ? T_RD_NEXT : T_PD_WIDTH;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int T_MAX = (M3 > T_PD_RECOV) ? M3 : T_PD_RECOV;
  localparam int TW = $clog2(T_MAX + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(CLK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);

  // ---------------- serializer ----------------
  logic              active, lowPhase, sclkR, outR, byteDoneR;
  logic [HW-1:0]     halfCnt;
  logic [BW-1:0]     bitCnt;
  logic [DATA_W-1:0] shreg, loadVal, wdataQ;

  always_comb begin
    unique case (ctl.src)
      SRC_ADDR:  loadVal = {reqWrite, reqAddr};
      SRC_WDATA: loadVal = wdataQ;
      default:   loadVal = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      lowPhase  <= 1'b0;
      sclkR     <= 1'b1;
      outR      <= 1'b1;
      byteDoneR <= 1'b0;
      halfCnt   <= '0;
      bitCnt    <= '0;
      shreg     <= '0;
    end else begin
      byteDoneR <= 1'b0;
      if (ctl.byteGo) begin
        // falling edge opens the first bit
        active   <= 1'b1;
        shreg    <= loadVal;
        outR     <= loadVal[DATA_W-1];
        sclkR    <= 1'b0;
        lowPhase <= 1'b1;
        halfCnt  <= HALF_LAST;
        bitCnt   <= BIT_LAST;
      end else if (active) begin
        if (halfCnt != '0) begin
          halfCnt <= halfCnt - 1'b1;
        end else if (lowPhase) begin
          // rising edge: both ends take the bit
          sclkR    <= 1'b1;
          lowPhase <= 1'b0;
          halfCnt  <= HALF_LAST;
          shreg    <= {shreg[DATA_W-2:0], sdioIn};
        end else if (bitCnt == '0) begin
          active    <= 1'b0;
          byteDoneR <= 1'b1;
        end else begin
          bitCnt   <= bitCnt - 1'b1;
          sclkR    <= 1'b0;
          lowPhase <= 1'b1;
          halfCnt  <= HALF_LAST;
          outR     <= shreg[DATA_W-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdataQ <= '0;
      rdData <= '0;
    end else begin
      if (ctl.latchReq) wdataQ <= reqWdata;
      if (ctl.capture)  rdData <= shreg;
    end
  end

  // ---------------- shared wait timer ----------------
  logic          running;
  logic [TW-1:0] tcnt, timerLoad;

  always_comb begin
    unique case (ctl.tsel)
      TM_PD:   timerLoad = TW'(T_PD_WIDTH - 1);
      TM_REC:  timerLoad = TW'(T_PD_RECOV - 1);
      TM_TURN: timerLoad = TW'(T_ADDR_DATA - 1);
      TM_WR:   timerLoad = TW'(T_WR_NEXT - 1);
      default: timerLoad = TW'(T_RD_NEXT - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      tcnt    <= '0;
    end else if (ctl.timerGo) begin
      running <= 1'b1;
      tcnt    <= timerLoad;
    end else if (running) begin
      if (tcnt == '0) running <= 1'b0;
      else            tcnt    <= tcnt - 1'b1;
    end
  end

  assign timerDone = running && (tcnt == '0);
  assign byteDone  = byteDoneR;
  assign sclk      = sclkR;
  assign sdioOut   = outR;

  // R2: clock rests high whenever no byte is being shifted
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> sclkR);

  // R3: data output only moves while the clock is low
  p_out_change_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outR) |-> !sclkR);
endmodule

// File: rtl/osm_ctrl.sv
module osm_ctrl
  import osm_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqStart,
  input  logic   reqWrite,
  input  logic   resyncReq,
  input  logic   byteDone,
  input  logic   timerDone,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done,
  output logic   pwrDown,
  output logic   sdioOe
);
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [3:0] {
    S_PDINIT, S_PDHOLD, S_PDREC, S_IDLE,
    S_ADDR, S_TURN, S_WRDATA, S_RDDATA, S_GAP
  } state_e;

  state_e state, stateNext;
  logic   oeR, oeNext, doneR, doneNext, wrQ;

  always_comb begin
    ctl       = '0;
    ctl.src   = SRC_RX;
    ctl.tsel  = TM_PD;
    stateNext = state;
    oeNext    = oeR;
    doneNext  = 1'b0;
    unique case (state)
      S_PDINIT: begin
        ctl.timerGo = 1'b1;
        ctl.tsel    = TM_PD;
        stateNext   = S_PDHOLD;
      end
      S_PDHOLD: if (timerDone) begin
        ctl.timerGo = 1'b1;
        ctl.tsel    = TM_REC;
        stateNext   = S_PDREC;
      end
      S_PDREC: if (timerDone) stateNext = S_IDLE;
      S_IDLE: begin
        if (resyncReq) begin
          stateNext = S_PDINIT;
        end else if (reqStart) begin
          ctl.latchReq = 1'b1;
          ctl.byteGo   = 1'b1;
          ctl.src      = SRC_ADDR;
          oeNext       = 1'b1;
          stateNext    = S_ADDR;
        end
      end
      S_ADDR: if (byteDone) begin
        if (wrQ) begin
          ctl.byteGo = 1'b1;
          ctl.src    = SRC_WDATA;
          stateNext  = S_WRDATA;
        end else begin
          oeNext      = 1'b0;
          ctl.timerGo = 1'b1;
          ctl.tsel    = TM_TURN;
          stateNext   = S_TURN;
        end
      end
      S_TURN: if (timerDone) begin
        ctl.byteGo = 1'b1;
        ctl.src    = SRC_RX;
        stateNext  = S_RDDATA;
      end
      S_WRDATA: if (byteDone) begin
        oeNext      = 1'b0;
        doneNext    = 1'b1;
        ctl.timerGo = 1'b1;
        ctl.tsel    = TM_WR;
        stateNext   = S_GAP;
      end
      S_RDDATA: if (byteDone) begin
        ctl.capture = 1'b1;
        doneNext    = 1'b1;
        ctl.timerGo = 1'b1;
        ctl.tsel    = TM_RD;
        stateNext   = S_GAP;
      end
      S_GAP: if (timerDone) stateNext = S_IDLE;
      default: stateNext = S_PDINIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_PDINIT;
      oeR   <= 1'b0;
      doneR <= 1'b0;
      wrQ   <= 1'b0;
    end else begin
      state <= stateNext;
      oeR   <= oeNext;
      doneR <= doneNext;
      if (ctl.latchReq) wrQ <= reqWrite;
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = doneR;
  assign pwrDown = (state == S_PDHOLD);
  assign sdioOe  = oeR;

  // R7: completion strobe lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: completion only while busy
  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R7: an accepted start makes the block busy
  p_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && reqStart && !resyncReq) |=> busy);

  // R1: line released during power-down
  p_pd_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> (busy && !sdioOe));

  // R5: line released through turnaround and read byte
  p_release_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TURN || state == S_RDDATA) |-> !oeR);

  // R10: resync in idle leads to power-down two cycles on
  p_resync_prio_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && resyncReq) |=> ##1 pwrDown);
endmodule

// File: rtl/optsens_serial_master.sv
module optsens_serial_master
  import osm_pkg::*;
#(
  parameter int CLK_HALF    = 2,
  parameter int T_ADDR_DATA = 12,
  parameter int T_WR_NEXT   = 10,
  parameter int T_RD_NEXT   = 6,
  parameter int T_PD_WIDTH  = 8,
  parameter int T_PD_RECOV  = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       reqWrite,
  input  logic [6:0] reqAddr,
  input  logic [7:0] reqWdata,
  input  logic       resyncReq,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdData,
  output logic       sclk,
  output logic       sdioOut,
  output logic       sdioOe,
  input  logic       sdioIn,
  output logic       pwrDown
);
  timeunit 1ns;
  timeprecision 1ps;

  dpCtl_t ctl;
  logic   byteDone, timerDone;

  osm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqStart (reqStart),
    .reqWrite (reqWrite),
    .resyncReq(resyncReq),
    .byteDone (byteDone),
    .timerDone(timerDone),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .pwrDown  (pwrDown),
    .sdioOe   (sdioOe)
  );

  osm_datapath #(
    .CLK_HALF   (CLK_HALF),
    .DATA_W     (8),
    .T_ADDR_DATA(T_ADDR_DATA),
    .T_WR_NEXT  (T_WR_NEXT),
    .T_RD_NEXT  (T_RD_NEXT),
    .T_PD_WIDTH (T_PD_WIDTH),
    .T_PD_RECOV (T_PD_RECOV)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .sdioIn   (sdioIn),
    .byteDone (byteDone),
    .timerDone(timerDone),
    .sclk     (sclk),
    .sdioOut  (sdioOut),
    .rdData   (rdData)
  );
endmodule

// File: tb/optsens_serial_master_test.sv
module optsens_serial_master_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF = 2;
  localparam int TAD  = 12;
  localparam int TWN  = 10;
  localparam int TRN  = 6;
  localparam int TPD  = 8;
  localparam int TREC = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqStart = 1'b0, reqWrite = 1'b0, resyncReq = 1'b0;
  logic [6:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic       busy, done, sclk, sdioOut, sdioOe, sdioIn, pwrDown;
  logic [7:0] rdData;

  always #4 clk = ~clk;  // 125 MHz

  optsens_serial_master #(
    .CLK_HALF(HALF), .T_ADDR_DATA(TAD), .T_WR_NEXT(TWN),
    .T_RD_NEXT(TRN), .T_PD_WIDTH(TPD), .T_PD_RECOV(TREC)
  ) uut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .resyncReq(resyncReq),
    .busy(busy), .done(done), .rdData(rdData), .sclk(sclk),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdioIn(sdioIn), .pwrDown(pwrDown)
  );

  // ---------------- sensor model ----------------
  int         cycNeg = 0;
  int         sCnt = 0, sPhase = 0, cmdCount = 0, rdGap = 0, addrRiseCyc = 0;
  int         glitchCount = 0, glitchSeen = 0;
  logic [7:0] sShift = '0, lastAddrByte = '0, rdLoad = '0;
  logic [6:0] sAddr = '0;
  logic       sDrive = 1'b0, sBitOut = 1'b1;
  logic       wrMask [128];
  logic [7:0] wrVal  [128];

  function automatic logic [7:0] defVal(input int a);
    return 8'(a * 29 + 7);
  endfunction

  assign sdioIn = sdioOe ? sdioOut : (sDrive ? sBitOut : 1'b1);

  always @(posedge sclk or posedge pwrDown) begin : sens_rx
    int c;
    logic [7:0] nb;
    if (pwrDown) begin
      sCnt <= 0;
      sPhase <= 0;
      glitchSeen <= glitchCount;
    end else begin
      c = sCnt;
      if (glitchSeen != glitchCount) begin
        c = c + 3;
        glitchSeen <= glitchCount;
      end
      nb = {sShift[6:0], sdioIn};
      sShift <= nb;
      if (c >= 7) begin
        sCnt <= 0;
        case (sPhase)
          0: begin
            lastAddrByte <= nb;
            sAddr <= nb[6:0];
            if (nb[7]) sPhase <= 1;
            else begin
              sPhase <= 2;
              rdLoad <= wrMask[nb[6:0]] ? wrVal[nb[6:0]] : defVal(int'(nb[6:0]));
              addrRiseCyc <= cycNeg;
            end
          end
          1: begin
            wrMask[sAddr] <= 1'b1;
            wrVal[sAddr] <= nb;
            sPhase <= 0;
            cmdCount <= cmdCount + 1;
          end
          default: begin
            sPhase <= 0;
            cmdCount <= cmdCount + 1;
          end
        endcase
      end else begin
        sCnt <= c + 1;
      end
    end
  end

  always @(negedge sclk or posedge pwrDown) begin
    if (pwrDown) sDrive <= 1'b0;
    else if (sPhase == 2) begin
      sDrive <= 1'b1;
      sBitOut <= rdLoad[3'(7 - sCnt)];
      if (sCnt == 0) rdGap <= cycNeg - addrRiseCyc;
    end else sDrive <= 1'b0;
  end

  // ---------------- line monitors ----------------
  int   contention = 0, badChange = 0, pdCycles = 0;
  logic prevOut = 1'b1, prevOe = 1'b0;
  always @(negedge clk) begin
    cycNeg <= cycNeg + 1;
    if (sdioOe && sDrive) contention <= contention + 1;
    if (sdioOe && prevOe && sdioOut != prevOut && sclk) badChange <= badChange + 1;
    if (pwrDown) pdCycles <= pdCycles + 1;
    prevOut <= sdioOut;
    prevOe  <= sdioOe;
  end

  // ---------------- check helpers ----------------
  int nChecks = 0, nFails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic measurePd(input string tag);
    int n, w, r;
    n = 0;
    while (!pwrDown && n < 100) begin @(negedge clk); n++; end
    chk(pwrDown, tag, "power-down seen", pwrDown, 1);
    w = 0;
    while (pwrDown && w < 1000) begin
      chk(sclk && !sdioOe, tag, "clock high, line released in power-down", {sclk, sdioOe}, 2'b10);
      w++;
      @(negedge clk);
    end
    chk(w == TPD, tag, "power-down width", w, TPD);
    r = 0;
    while (busy && r < 1000) begin @(negedge clk); r++; end
    chk(r == TREC, tag, "recovery length", r, TREC);
  endtask

  task automatic doXfer(input bit wr, input logic [6:0] a, input logic [7:0] d,
                        output int gap);
    int n;
    n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    reqStart = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqStart = 1'b0; reqAddr = ~a; reqWdata = ~d; reqWrite = ~wr;
    chk(busy, "R7", "busy after start", busy, 1);
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done && busy, "R7", "done seen while busy", {done, busy}, 2'b11);
    @(negedge clk);
    chk(!done, "R7", "done lasts one cycle", done, 0);
    gap = 1;
    while (busy && gap < 3000) begin @(negedge clk); gap++; end
    chk(sclk && !sdioOe, "R2", "idle clock high, line released", {sclk, sdioOe}, 2'b10);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(sclk && !sdioOe && !pwrDown, "R1", "reset outputs",
        {sclk, sdioOe, pwrDown}, 3'b100);
    chk(!done, "R1", "no done in reset", done, 0);
    rstN = 1'b1;
    measurePd("R1");
  endtask

  task automatic t_write(input logic [6:0] a, input logic [7:0] d);
    int g;
    doXfer(1'b1, a, d, g);
    chk(lastAddrByte == {1'b1, a}, "R3", "write address byte", lastAddrByte, {1'b1, a});
    chk(wrVal[a] == d, "R4", "sensor register after write", wrVal[a], d);
    chk(g == TWN, "R8", "write spacing", g, TWN);
  endtask

  task automatic t_read(input logic [6:0] a, input logic [7:0] exp);
    int g;
    doXfer(1'b0, a, 8'h00, g);
    chk(lastAddrByte == {1'b0, a}, "R3", "read address byte", lastAddrByte, {1'b0, a});
    chk(rdData == exp, "R6", "read data", rdData, exp);
    chk(g == TRN, "R8", "read spacing", g, TRN);
    chk(rdGap >= TAD, "R5", "address-to-data wait", rdGap, TAD);
  endtask

  task automatic t_ignore_busy();
    int c0, p0, n;
    c0 = cmdCount; p0 = pdCycles;
    reqStart = 1'b1; reqWrite = 1'b1; reqAddr = 7'h05; reqWdata = 8'h11;
    @(negedge clk);
    reqStart = 1'b0;
    repeat (10) @(negedge clk);
    reqStart = 1'b1; reqWrite = 1'b0; reqAddr = 7'h09; resyncReq = 1'b1;
    @(negedge clk);
    reqStart = 1'b0; resyncReq = 1'b0;
    n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    repeat (20) begin
      @(negedge clk);
      chk(!busy, "R9", "no extra command after busy", busy, 0);
    end
    chk(cmdCount == c0 + 1, "R9", "frames on the line", cmdCount, c0 + 1);
    chk(pdCycles == p0, "R9", "no power-down from busy request", pdCycles, p0);
    chk(wrVal[5] == 8'h11, "R9", "accepted write intact", wrVal[5], 8'h11);
  endtask

  task automatic t_resync();
    int c0;
    c0 = cmdCount;
    glitchCount = glitchCount + 1;  // sensor loses bit alignment
    @(negedge clk);
    resyncReq = 1'b1; reqStart = 1'b1; reqWrite = 1'b1; reqAddr = 7'h03; reqWdata = 8'hEE;
    @(negedge clk);
    resyncReq = 1'b0; reqStart = 1'b0;
    measurePd("R10");
    chk(cmdCount == c0, "R10", "start lost to resync", cmdCount, c0);
    t_write(7'h2C, 8'h96);
    t_read(7'h2C, 8'h96);
  endtask

  task automatic run_all();
    t_reset();
    @(negedge clk);
    chk(!busy && sclk && !sdioOe, "R2", "idle after start-up", {busy, sclk, sdioOe}, 3'b010);
    t_write(7'h12, 8'h55);
    t_write(7'h7F, 8'hA3);
    t_write(7'h00, 8'h00);
    t_write(7'h40, 8'hFF);
    t_read(7'h12, 8'h55);
    t_read(7'h7F, 8'hA3);
    t_read(7'h00, 8'h00);
    t_read(7'h40, 8'hFF);
    t_read(7'h21, defVal(7'h21));
    t_read(7'h6A, defVal(7'h6A));
    repeat (15) @(negedge clk);
    chk(rdData == defVal(7'h6A), "R6", "read data held", rdData, defVal(7'h6A));
    t_write(7'h6A, 8'h3C);
    chk(rdData == defVal(7'h6A), "R6", "read data held over write", rdData, defVal(7'h6A));
    t_ignore_busy();
    t_resync();
    chk(contention == 0, "R5", "cycles with both ends driving", contention, 0);
    chk(badChange == 0, "R3", "data changes while clock high", badChange, 0);
  endtask

  initial begin
    bit wdFired;
    wdFired = 1'b0;
    for (int i = 0; i < 128; i++) begin
      wrMask[i] = 1'b0;
      wrVal[i] = '0;
    end
    fork
      run_all();
      begin
        repeat (200000) @(negedge clk);
        wdFired = 1'b1;
      end
    join_any
    disable fork;
    if (wdFired) begin
      nChecks++;
      nFails++;
      $display("FAIL R7 watchdog: busy actual=%0d expected=0", busy);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule